// File: doc/BRIEF.md
# External Bus Transfer Terminator

This block runs one access at a time on an external asynchronous memory bus. An internal requester hands it an address, a direction and, for writes, a data word. The block then asserts a single active-low chip select and holds it until the transfer is acknowledged. The acknowledge can come from the external device on an input pin. It can also come from the block itself, when auto-acknowledge is enabled and a programmed number of wait states has elapsed.

The external acknowledge is asynchronous. It passes through a synchroniser before use and only counts while the chip select is active. When auto-acknowledge is on, whichever acknowledge is recognised first ends the access. A read captures the data pins in the cycle the acknowledge is recognised. A write keeps driving its data for one clock after the chip select is released. The requester sees a one-cycle done pulse when the chip select goes inactive. New requests are taken only while the block is idle.

Top module: `xbus_term`

## Requirements
- R1: After reset, bus_cs_n is 1, req_ready is 1, rsp_done is 0 and bus_data_oe is 0.
- R2: A request is taken at a clock edge where req_valid and req_ready are both 1. bus_cs_n is 0 from the next cycle on, and req_ready stays 0 until the access has fully finished.
- R3: With cfg_auto_ack = 1 and cfg_wait = N, taken at request time, and no external acknowledge, bus_cs_n stays 0 for exactly N+1 cycles. N = 0 gives a single cycle.
- R4: With cfg_auto_ack = 0, only bus_ack_in can end the access, and with no acknowledge the chip select stays active indefinitely. A bus_ack_in first sampled high at the edge ending active cycle k (cycles counted from 0) is recognised in active cycle k+2, which is the last active cycle.
- R5: With cfg_auto_ack = 1, an external acknowledge recognised before the countdown expires ends the access in the cycle it is recognised. If both acknowledges land in the same cycle, the access ends there once.
- R6: bus_cs_n returns to 1 one clock after the cycle in which the acknowledge is recognised. rsp_done is 1 for exactly that first inactive cycle and 0 at all other times.
- R7: On a read (req_write = 0), rsp_rdata takes the value bus_data_in had at the edge that ends the last active cycle, and holds it until the next read completes.
- R8: On a write, bus_data_oe is 1 during every active cycle and for exactly one cycle after bus_cs_n returns to 1, with bus_data_out equal to the request's write data. On a read, bus_data_oe stays 0.
- R9: bus_ack_in asserted while bus_cs_n is 1 is ignored. It produces no done pulse and does not shorten the next access.
- R10: While bus_cs_n is 0, bus_addr equals the request address and bus_rnw is 1 for a read and 0 for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Requester presents an access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Block idle, a request will be taken |
| rsp_done | output | 1 | One-cycle pulse when the access finishes |
| rsp_rdata | output | DW | Data captured by the last read |
| cfg_auto_ack | input | 1 | Enable the internally generated acknowledge |
| cfg_wait | input | WSW | Wait states before the internal acknowledge |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rnw | output | 1 | Bus direction, 1 = read |
| bus_addr | output | AW | Bus address |
| bus_ack_in | input | 1 | External acknowledge, asynchronous |
| bus_data_in | input | DW | Data pins, input side |
| bus_data_out | output | DW | Data pins, output side |
| bus_data_oe | output | 1 | Output enable for bus_data_out |

## Verification
The external acknowledge and the internal countdown can both become true in the same active cycle. The bench provokes this by raising bus_ack_in two cycles before the programmed wait count expires. It also mixes random early, late and coincident acknowledge timings. Each case is judged by counting the active chip-select cycles against the earlier of the two predicted end cycles and by confirming that exactly one done pulse follows. A captured read word, tagged with its cycle index, must come from that same end cycle.

// File: rtl/xbus_term_pkg.sv
package xbus_term_pkg;
   typedef enum logic [1:0] {
      XB_IDLE   = 2'd0,
      XB_ACTIVE = 2'd1,
      XB_HOLD   = 2'd2
   } xb_state_t;
endpackage

// File: rtl/xbus_ack_sync.sv
// Multi-stage synchroniser for the asynchronous acknowledge pin.
// The chain is flushed while clr is high, so stale pulses never survive.
module xbus_ack_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("xbus_ack_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   chain_q[0] <= 1'b0;
      else if (clr) chain_q[0] <= 1'b0;
      else          chain_q[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   chain_q[s] <= 1'b0;
         else if (clr) chain_q[s] <= 1'b0;
         else          chain_q[s] <= chain_q[s-1];
      end
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/xbus_wait_cnt.sv
// Down-counter for wait states; expired is high once the count reaches zero.
module xbus_wait_cnt #(
   parameter int WSW = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic [WSW-1:0] load_val,
   input  logic           run,
   output logic           expired
);
   if (WSW < 1 || WSW > 16) begin : g_bad_wsw
      $error("xbus_wait_cnt: WSW out of range 1..16");
   end

   logic [WSW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt_q <= '0;
      else if (load)                  cnt_q <= load_val;
      else if (run && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/xbus_term.sv
module xbus_term
   import xbus_term_pkg::*;
#(
   parameter int AW          = 16,
   parameter int DW          = 16,
   parameter int WSW         = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           req_valid,
   input  logic           req_write,
   input  logic [AW-1:0]  req_addr,
   input  logic [DW-1:0]  req_wdata,
   output logic           req_ready,
   output logic           rsp_done,
   output logic [DW-1:0]  rsp_rdata,
   input  logic           cfg_auto_ack,
   input  logic [WSW-1:0] cfg_wait,
   output logic           bus_cs_n,
   output logic           bus_rnw,
   output logic [AW-1:0]  bus_addr,
   input  logic           bus_ack_in,
   input  logic [DW-1:0]  bus_data_in,
   output logic [DW-1:0]  bus_data_out,
   output logic           bus_data_oe
);
   if (AW < 1 || DW < 1) begin : g_bad_width
      $error("xbus_term: AW and DW must be positive");
   end

   xb_state_t      st_q;
   logic           wr_q;
   logic           auto_q;
   logic [AW-1:0]  addr_q;
   logic [DW-1:0]  wdata_q;
   logic [DW-1:0]  rdata_q;
   logic           done_q;

   logic active, accept, ext_sync, ext_ack, wait_done, int_ack, ack_hit;

   assign active = (st_q == XB_ACTIVE);
   assign accept = req_valid && (st_q == XB_IDLE);

   xbus_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!active),
      .d     (bus_ack_in),
      .q     (ext_sync)
   );

   xbus_wait_cnt #(.WSW(WSW)) u_wait (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_val (cfg_wait),
      .run      (active),
      .expired  (wait_done)
   );

   assign ext_ack = active && ext_sync;
   assign int_ack = active && auto_q && wait_done;
   assign ack_hit = ext_ack || int_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= XB_IDLE;
         wr_q    <= 1'b0;
         auto_q  <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else begin
         unique case (st_q)
            XB_IDLE: if (accept) begin
               st_q    <= XB_ACTIVE;
               wr_q    <= req_write;
               auto_q  <= cfg_auto_ack;
               addr_q  <= req_addr;
               wdata_q <= req_wdata;
            end
            XB_ACTIVE: if (ack_hit) st_q <= wr_q ? XB_HOLD : XB_IDLE;
            XB_HOLD:   st_q <= XB_IDLE;
            default:   st_q <= XB_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= ack_hit;
         if (ack_hit && !wr_q) rdata_q <= bus_data_in;
      end
   end

   assign req_ready    = (st_q == XB_IDLE);
   assign rsp_done     = done_q;
   assign rsp_rdata    = rdata_q;
   assign bus_cs_n     = !active;
   assign bus_rnw      = !wr_q;
   assign bus_addr     = addr_q;
   assign bus_data_out = wdata_q;
   assign bus_data_oe  = wr_q && (st_q != XB_IDLE);
endmodule

// File: rtl/xbus_term_chk.sv
module xbus_term_chk #(
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_ready,
   input logic          rsp_done,
   input logic          bus_cs_n,
   input logic          bus_data_oe,
   input logic [DW-1:0] bus_data_out
);
   // R2: while a transfer owns the bus no new request is offered
   p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_cs_n |-> !req_ready);

   // R6: done coincides with the chip select being released
   p_done_on_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_cs_n) |-> rsp_done);

   // R6: done lasts a single cycle
   p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   // R9: no done while the chip select has been idle for two cycles
   p_idle_no_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cs_n && $past(bus_cs_n)) |-> !rsp_done);

   // R8: write data stays driven in the first cycle after release
   p_wdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(bus_cs_n) && $past(bus_data_oe)) |-> bus_data_oe);

   // R8: the hold lasts exactly one cycle
   p_wdata_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_data_oe && bus_cs_n) |=> !bus_data_oe);

   // R8: driven data does not change mid-transfer
   p_wdata_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_data_oe && $past(bus_data_oe)) |-> $stable(bus_data_out));
endmodule

bind xbus_term xbus_term_chk #(.DW(DW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_ready    (req_ready),
   .rsp_done     (rsp_done),
   .bus_cs_n     (bus_cs_n),
   .bus_data_oe  (bus_data_oe),
   .bus_data_out (bus_data_out)
);

// File: tb/xbus_term_test.sv
`timescale 1ns/1ps
module xbus_term_test;
   localparam int AW = 16;
   localparam int DW = 16;
   localparam int WSW = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           req_valid = 1'b0;
   logic           req_write = 1'b0;
   logic [AW-1:0]  req_addr = '0;
   logic [DW-1:0]  req_wdata = '0;
   logic           req_ready;
   logic           rsp_done;
   logic [DW-1:0]  rsp_rdata;
   logic           cfg_auto_ack = 1'b0;
   logic [WSW-1:0] cfg_wait = '0;
   logic           bus_cs_n;
   logic           bus_rnw;
   logic [AW-1:0]  bus_addr;
   logic           bus_ack_in = 1'b0;
   logic [DW-1:0]  bus_data_in = '0;
   logic [DW-1:0]  bus_data_out;
   logic           bus_data_oe;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   xbus_term #(.AW(AW), .DW(DW), .WSW(WSW), .SYNC_STAGES(2)) uut (.*);

   function automatic logic [DW-1:0] pat(input logic [DW-1:0] base, input int idx);
      return base ^ DW'(idx * 16'h0111);
   endfunction

   function automatic int end_idx(input bit au, input int ws, input bit ext, input int e);
      int r;
      r = au ? ws : 100000;
      if (ext && (e + 2) < r) r = e + 2;
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic xfer(input bit wr, input bit au, input int ws, input bit ext,
                       input int e, input string tag);
      logic [AW-1:0] a;
      logic [DW-1:0] wd, base;
      int exp_end, idx;
      bit side_ok;
      a = AW'($urandom); wd = DW'($urandom); base = DW'($urandom);
      exp_end = end_idx(au, ws, ext, e);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
      cfg_auto_ack = au; cfg_wait = WSW'(ws);
      @(negedge clk);
      req_valid = 1'b0;
      chk(bus_cs_n == 1'b0 && req_ready == 1'b0, "R2 cs active after accept",
          {bus_cs_n, req_ready}, 0);
      idx = 0; side_ok = 1;
      while (!bus_cs_n && idx < 300) begin
         if (bus_addr != a || bus_rnw != !wr) side_ok = 0;
         if (bus_data_oe != wr || rsp_done) side_ok = 0;
         if (wr && bus_data_out != wd) side_ok = 0;
         bus_data_in = pat(base, idx);
         if (ext && idx == e) bus_ack_in = 1'b1;
         idx++;
         @(negedge clk);
      end
      bus_ack_in = 1'b0;
      chk(side_ok, "R10/R8 bus signals during active cycles", side_ok, 1);
      chk(idx == exp_end + 1, tag, idx, exp_end + 1);
      chk(rsp_done == 1'b1 && bus_cs_n == 1'b1, "R6 done with cs release",
          {rsp_done, bus_cs_n}, 2'b11);
      if (wr)
         chk(bus_data_oe == 1'b1 && bus_data_out == wd, "R8 write data held",
             {bus_data_oe, bus_data_out}, {1'b1, wd});
      else
         chk(rsp_rdata == pat(base, exp_end), "R7 read capture",
             rsp_rdata, pat(base, exp_end));
      @(negedge clk);
      chk(rsp_done == 0 && bus_data_oe == 0 && req_ready == 1, "R6/R8 return to idle",
          {rsp_done, bus_data_oe, req_ready}, 3'b001);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : stim
      bit ok;
      void'($urandom(32'h5EED_0BA5));
      repeat (3) @(negedge clk);
      chk(bus_cs_n == 1 && req_ready == 1 && rsp_done == 0 && bus_data_oe == 0,
          "R1 reset state", {bus_cs_n, req_ready, rsp_done, bus_data_oe}, 4'b1100);
      rst_n = 1'b1;
      @(negedge clk);

      xfer(0, 1, 0, 0, 0, "R3 zero wait single cycle");
      xfer(1, 1, 0, 0, 0, "R3 zero wait write");
      xfer(0, 1, 5, 0, 0, "R3 five wait states");
      xfer(1, 1, 15, 0, 0, "R3 max wait states");
      xfer(0, 0, 0, 1, 3, "R4 external ack only");
      xfer(1, 0, 0, 1, 60, "R4 long hang then ack");
      xfer(0, 1, 9, 1, 1, "R5 early external ack");
      xfer(1, 1, 6, 1, 4, "R5 coincident acks");
      xfer(0, 1, 2, 1, 7, "R5 late external ack");

      // R9: acknowledge while idle is ignored
      ok = 1;
      @(negedge clk);
      bus_ack_in = 1'b1;
      repeat (6) begin
         @(negedge clk);
         if (!bus_cs_n || rsp_done) ok = 0;
      end
      bus_ack_in = 1'b0;
      chk(ok, "R9 idle ack no effect", ok, 1);
      xfer(0, 1, 4, 0, 0, "R9 next access not shortened");

      for (int t = 0; t < 40; t++) begin
         bit wr, au, ext;
         int ws, e;
         wr = 1'($urandom); au = 1'($urandom); ext = 1'($urandom);
         ws = int'($urandom % 8); e = int'($urandom % 10);
         if (!au) ext = 1;
         xfer(wr, au, ws, ext, e, au ? "R5 random auto" : "R4 random external");
      end

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule